// File: doc/BRIEF.md
# Single-Channel Block DMA Controller with Burst and Cycle-Steal Modes

This block copies a block of bytes from an I/O device into memory. The device hands bytes to the controller through a valid/acknowledge handshake. The controller holds one byte at a time and writes it to memory through a single-cycle write port. That port is on a system bus shared with the CPU, and ownership of the bus is settled by a level request output and a grant input.

Software programs a base address, a byte count and a mode bit, then writes the start command. The mode bit selects between two policies. In burst mode the controller keeps the bus from its first grant until the whole block is written, so the CPU is locked out for one long stretch. In cycle-steal mode the controller gives the bus back after every byte and requests it again for the next one, so the CPU gets bus cycles in between. The CPU is never interrupted; it only waits when it wants the bus while the controller owns it. Completion is signalled by a one-cycle pulse.

Top module: `dma_xfer_ctrl`

## Requirements
- R1: During and right after reset, bus_req, mem_we, dev_ack and done are all low.
- R2: mem_we is high only while bus_grant and bus_req are both high. Each write carries one byte. Bytes arrive in the order the device offered them, and the write address starts at the programmed base and rises by one per write.
- R3: In burst mode (mode bit 0 = 0), bus_req stays high from its first rise until the cycle after the final write. A block of N bytes therefore sees exactly one grant, even when the device is slow.
- R4: In cycle-steal mode (mode bit 0 = 1), bus_req is low in the cycle after every write. A block of N bytes therefore sees exactly N separate grants.
- R5: bus_req rises only while a latched byte is waiting to be written.
- R6: dev_ack is high only in a cycle where dev_valid is high and the controller takes the byte. The controller can take a new byte in the same cycle it writes out the held one. Across a block it takes exactly as many bytes as the programmed count.
- R7: done pulses high for exactly one cycle, in the cycle after the final write. The controller is then idle and neither requests the bus nor writes.
- R8: A start issued with a count of zero pulses done in the next cycle and never raises bus_req.
- R9: Configuration writes, including start, are ignored while a transfer is in progress.
- R10: The configuration select codes are 0 for base address, 1 for byte count (low CNT_W bits of the write data), 2 for mode (bit 0) and 3 for start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| dev_valid | input | 1 | Device has a byte on dev_data |
| dev_data | input | DATA_W | Device byte |
| dev_ack | output | 1 | Byte taken this cycle |
| bus_grant | input | 1 | Bus granted to the controller |
| bus_req | output | 1 | Bus request (level) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | ADDR_W | Memory write address |
| mem_wdata | output | DATA_W | Memory write data |
| done | output | 1 | One-cycle completion pulse |

## Verification
The interesting collision is a memory write of the held byte in the same cycle as the latch of the next device byte, with dev_ack and mem_we both high. This is the only way a burst can write a byte every cycle. The bench provokes it by keeping dev_valid high through long bursts, and provokes its absence with a device that is valid only every third cycle. A behavioural model predicts both strobes on every clock. The bytes collected in memory are then compared in order against the device stream, which shows that nothing was lost or taken twice.

// File: rtl/dma_xfer_ctrl.sv
module dma_xfer_ctrl #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              dev_valid,
  input  logic [DATA_W-1:0] dev_data,
  output logic              dev_ack,
  input  logic              bus_grant,
  output logic              bus_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              done
);
  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_CNT   = 2'd1;
  localparam logic [1:0] SEL_MODE  = 2'd2;
  localparam logic [1:0] SEL_START = 2'd3;

  logic              busy, steal, hold_full, req_q, done_q;
  logic [CNT_W-1:0]  cnt;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] hold_q;
  logic              cfg_ok, start, last, req_d;

  assign cfg_ok    = cfg_we && !busy;
  assign start     = cfg_ok && (cfg_sel == SEL_START);
  assign last      = (cnt == CNT_W'(1));
  assign mem_we    = busy && bus_grant && req_q && hold_full;
  assign dev_ack   = busy && dev_valid && (!hold_full || (mem_we && !last));
  assign bus_req   = req_q;
  assign done      = done_q;
  assign mem_addr  = addr;
  assign mem_wdata = hold_q;

  always_comb begin
    if (!busy)        req_d = 1'b0;
    else if (mem_we)  req_d = !steal && !last;
    else if (req_q)   req_d = 1'b1;
    else              req_d = hold_full;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      steal     <= 1'b0;
      hold_full <= 1'b0;
      req_q     <= 1'b0;
      done_q    <= 1'b0;
      cnt       <= '0;
      addr      <= '0;
      hold_q    <= '0;
    end else begin
      req_q  <= req_d;
      done_q <= (mem_we && last) || (start && cnt == '0);
      if (cfg_ok && cfg_sel == SEL_ADDR) addr  <= cfg_wdata;
      if (cfg_ok && cfg_sel == SEL_CNT)  cnt   <= cfg_wdata[CNT_W-1:0];
      if (cfg_ok && cfg_sel == SEL_MODE) steal <= cfg_wdata[0];
      if (start && cnt != '0) busy <= 1'b1;
      if (mem_we) begin
        addr <= addr + ADDR_W'(1);
        cnt  <= cnt - CNT_W'(1);
        if (last) busy <= 1'b0;
      end
      if (dev_ack) begin
        hold_full <= 1'b1;
        hold_q    <= dev_data;
      end else if (mem_we) begin
        hold_full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dma_xfer_ctrl_chk.sv
module dma_xfer_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic bus_req,
  input logic bus_grant,
  input logic mem_we,
  input logic dev_ack,
  input logic dev_valid,
  input logic done,
  input logic busy,
  input logic steal,
  input logic hold_full
);
  AST_WE_OWNED:    assert property (@(posedge clk) disable iff (!rst_n) mem_we |-> (bus_grant && bus_req)); // R2
  AST_BURST_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) ($fell(bus_req) && !steal) |-> done); // R3
  AST_STEAL_DROP:  assert property (@(posedge clk) disable iff (!rst_n) (mem_we && steal) |=> !bus_req); // R4
  AST_REQ_HAS_BYTE: assert property (@(posedge clk) disable iff (!rst_n) $rose(bus_req) |-> hold_full); // R5
  AST_ACK_VALID:   assert property (@(posedge clk) disable iff (!rst_n) dev_ack |-> dev_valid); // R6
  AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
  AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (!bus_req && !mem_we)); // R7
  AST_ZERO_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n) (done && !$past(mem_we)) |-> !bus_req); // R8
endmodule

bind dma_xfer_ctrl dma_xfer_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .mem_we(mem_we), .dev_ack(dev_ack), .dev_valid(dev_valid), .done(done),
  .busy(busy), .steal(steal), .hold_full(hold_full)
);

// File: tb/dma_xfer_ctrl_tb_top.sv
module dma_xfer_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic        dev_valid = 1'b0;
  logic [7:0]  dev_data = '0;
  logic        dev_ack, bus_req, mem_we, done;
  logic        bus_grant = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;

  always #2 clk = ~clk;

  dma_xfer_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .dev_valid(dev_valid), .dev_data(dev_data), .dev_ack(dev_ack),
    .bus_grant(bus_grant), .bus_req(bus_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done)
  );

  int errors = 0, checks = 0;
  int cyc = 0, dev_idx = 0, dv_div = 1, hold_en = 0;
  int grants = 0, dones = 0, reqs_seen = 0;
  bit g_prev = 0, finished = 0;
  logic [7:0] mem [int];

  // behavioural reference state
  bit m_busy = 0, m_steal = 0, m_full = 0, m_req = 0, m_done = 0;
  int m_cnt = 0, m_addr = 0, m_hold = 0;

  function automatic logic [7:0] stream(int k);
    return 8'((k * 37 + 5) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit e_we, e_ack, start, n_req, n_done;
    dev_valid = (dv_div == 1) || (cyc % dv_div == 0);
    dev_data  = stream(dev_idx);
    bus_grant = bus_req && (g_prev || !(hold_en != 0 && (cyc % 5) < 2));
    #1;
    e_we  = m_busy && bus_grant && m_req && m_full;
    e_ack = m_busy && dev_valid && (!m_full || (e_we && m_cnt > 1));
    chk(bus_req == m_req, "R5 bus_req", int'(bus_req), int'(m_req));
    chk(done == m_done, "R7 done", int'(done), int'(m_done));
    chk(mem_we == e_we, "R2 mem_we", int'(mem_we), int'(e_we));
    chk(dev_ack == e_ack, "R6 dev_ack", int'(dev_ack), int'(e_ack));
    if (mem_we && e_we) begin
      chk(int'(mem_addr) == m_addr, "R2 mem_addr", int'(mem_addr), m_addr);
      chk(int'(mem_wdata) == m_hold, "R2 mem_wdata", int'(mem_wdata), m_hold);
    end
    if (mem_we) mem[int'(mem_addr)] = mem_wdata;
    if (bus_grant && bus_req && !g_prev) grants++;
    if (bus_req) reqs_seen++;
    if (done) dones++;
    if (dev_ack) dev_idx++;
    // model update at the coming edge
    start  = cfg_we && !m_busy && cfg_sel == 2'd3;
    n_done = (e_we && m_cnt == 1) || (start && m_cnt == 0);
    if (!m_busy)      n_req = 0;
    else if (e_we)    n_req = !m_steal && m_cnt != 1;
    else if (m_req)   n_req = 1;
    else              n_req = m_full;
    if (cfg_we && !m_busy) begin
      case (cfg_sel)
        2'd0: m_addr = int'(cfg_wdata);
        2'd1: m_cnt = int'(cfg_wdata);
        2'd2: m_steal = cfg_wdata[0];
        default: if (m_cnt != 0) m_busy = 1;
      endcase
    end
    if (e_we) begin
      m_addr = (m_addr + 1) % 65536;
      if (m_cnt == 1) m_busy = 0;
      m_cnt = m_cnt - 1;
    end
    if (e_ack) begin m_full = 1; m_hold = int'(dev_data); end
    else if (e_we) m_full = 0;
    m_req = n_req;
    m_done = n_done;
    g_prev = bus_grant;
    cyc++;
    @(negedge clk);
  endtask

  // R10: select codes 0 addr, 1 count, 2 mode bit0, 3 start
  task automatic cfg_write(input logic [1:0] sel, input int val);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = 16'(val);
    step();
    cfg_we = 0;
  endtask

  task automatic run_block(input bit steal, input int base, input int len,
                           input int div, input int hold, input bit poke);
    int first;
    mem.delete();
    dv_div = div; hold_en = hold; grants = 0; dones = 0; reqs_seen = 0;
    cfg_write(2'd0, base);
    cfg_write(2'd1, len);
    cfg_write(2'd2, int'(steal));
    first = dev_idx;
    cfg_write(2'd3, 0);
    for (int i = 0; i < 20 * len + 50 && dones == 0; i++) begin
      if (poke && i == 3) begin
        cfg_we = 1; cfg_sel = 2'd0; cfg_wdata = 16'hF000;
        step();
        cfg_sel = 2'd1; cfg_wdata = 16'd2;
        step();
        cfg_sel = 2'd3;
        step();
        cfg_we = 0;
      end else step();
    end
    for (int i = 0; i < 4; i++) step();
    chk(dones == 1, "R7 done pulses", dones, 1);
    chk(dev_idx - first == len, "R6 bytes taken", dev_idx - first, len);
    chk(mem.num() == len, "R9 write count", mem.num(), len);
    for (int i = 0; i < len; i++)
      chk(mem.exists((base + i) % 65536) && mem[(base + i) % 65536] == stream(first + i),
          "R2 memory byte", mem.exists((base + i) % 65536) ? int'(mem[(base + i) % 65536]) : -1,
          int'(stream(first + i)));
    if (steal) chk(grants == len, "R4 grants", grants, len);
    else       chk(grants == 1, "R3 grants R10", grants, 1);
    chk(bus_req == 0, "R7 idle req", int'(bus_req), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    rst_n = 0;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(!bus_req && !mem_we && !dev_ack && !done, "R1 reset outputs",
          int'({bus_req, mem_we, dev_ack, done}), 0);
      @(negedge clk);
    end
    rst_n = 1;
    step();
    run_block(0, 16'h0100, 8, 1, 0, 0);
    run_block(1, 16'h0200, 8, 1, 0, 0);
    run_block(0, 16'h0300, 12, 3, 1, 0);
    run_block(1, 16'h0400, 12, 3, 1, 0);
    run_block(0, 16'h0500, 10, 1, 0, 1);
    run_block(1, 16'hFFFC, 6, 2, 0, 0);
    // R8: zero count
    dones = 0; reqs_seen = 0;
    cfg_write(2'd1, 0);
    cfg_write(2'd3, 0);
    for (int i = 0; i < 6; i++) step();
    chk(dones == 1, "R8 zero-count done", dones, 1);
    chk(reqs_seen == 0, "R8 zero-count req", reqs_seen, 0);
    run_block(0, 16'h1000, 1000, 1, 0, 0);
    run_block(1, 16'h2000, 1000, 1, 1, 0);
    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule